// File: doc/BRIEF.md
# Multi-Personality Bank Address Translator

This block sits between a CPU write port and the banking logic of a cartridge-style memory map. It watches CPU register writes and turns them into bank numbers for four 8 KB program windows and eight 1 KB character windows. It also produces a nametable mirroring selection. The windows and the mirroring output are combinational views of the register state. A write therefore shows on the outputs right after the clock edge that captures it.

A mode register picks the register personality that decodes writes at 0x8000 and above. The nibble personality has character registers that are each addressed directly and loaded four bits at a time. The indexed personality uses a control register to select which data register the next data write lands in. One mode bit acts as an outer character-bank bit for both personalities. Program banks that are fixed to the "last" or "second-last" bank are taken from a power-of-two ROM-size parameter. Every program bank number is reduced modulo that size.

Top module: `multi_bank_xlate`

## Requirements
- R1: After a synchronous active-low reset, the mode is 0 and the outputs are as follows. Program windows 0..3 are 0, 1, PRG_BANKS-2 and PRG_BANKS-1. Character windows 0..7 are 0xFF, 0xFF, 0xFF, 0xFF, 4, 5, 6, 7. The mirroring output is 0 (vertical).
- R2: The mode register takes wr_data[2:0] on a write whose address is below 0x8000 and satisfies (address & 0x4100) == 0x4100. Any other write below 0x8000 changes no output.
- R3: Mode bit 2 adds 0x100 to every character window bank. It sets bit 8 of each 9-bit character bank, in every mode.
- R4: In mode 0, bank numbers are set by writes where (address & 0xF000) is 0x8000 (program window 0) or 0xA000 (program window 1). Program windows 2 and 3 always show the second-last and last banks.
- R5: In mode 0, a write with an address from 0xB000 to 0xE003 inclusive updates one nibble of character register ((((a & 2) | (a >> 10)) >> 1) + 2) & 7. With address bit 0 set, it writes wr_data[3:0] into the high nibble; with bit 0 clear, into the low nibble. The other nibble is kept. Window k shows register k.
- R6: In mode 0, a write with (address & 0xF000) == 0x9000 sets the mirroring output to wr_data[0] (1 horizontal, 0 vertical).
- R7: In mode 1, writes at 0x8000 and above are decoded with mask 0xE001. 0x8000 loads the control byte. 0x8001 loads data register [control & 7]. 0xA000 sets the mirroring output to wr_data[0]. Other decoded addresses change no output.
- R8: In mode 1, program window 1 shows register 7 and window 3 shows the last bank. With control bit 6 clear, window 0 shows register 6 and window 2 the second-last bank. With bit 6 set, the two are swapped.
- R9: In mode 1, logical slots 0..7 take these values: reg0 with bit 0 cleared, reg0 with bit 0 set, reg1 with bit 0 cleared, reg1 with bit 0 set, then reg2, reg3, reg4 and reg5. Logical slot s drives window s XOR 4 when control bit 7 is set, and window s otherwise.
- R10: At reset, mode-1 data registers 0..7 hold 0, 2, 4, 5, 6, 7, 0xFC, 0xFD, and the control byte is 0.
- R11: With mode bits [1:0] equal to 2 or 3, writes at 0x8000 and above change no output. The windows and mirroring follow the mode-0 resolution of the retained mode-0 registers.
- R12: Each program window output is the selected 8-bit bank number modulo PRG_BANKS (its low log2(PRG_BANKS) bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_banks | output | 4*PRG_W | Program window banks, window w at [w*PRG_W +: PRG_W] |
| chr_banks | output | 72 | Character window banks, window k at [k*9 +: 9] |
| mirror_h | output | 1 | Mirroring: 1 horizontal, 0 vertical |

## Verification
The bench aims at the address-decoding edges. The mode-register mask is tested with addresses that match on only one of its two bits; a decoder that checks just one bit would switch personality on stray writes. Nibble writes at the ends of the character range, including 0xE003 and the first address past it, expose an off-by-one range compare or a swapped nibble select, which would corrupt the wrong register half. The indexed personality is exercised with both control swap bits and with the reset contents of its data registers. A missed XOR or a wrong slot pairing would then show as a misplaced character bank, and a wrong reset constant as a bad program window right after the mode switch. Modes 2 and 3 are hit with high writes that must leave every output unchanged.

// File: rtl/mbt_pkg.sv
// Package: shared constants and helpers for the bank address translator.
// Assumes a 16-bit CPU address and 8-bit data bus.
package mbt_pkg;

    localparam int CPU_AW      = 16;
    localparam int CPU_DW      = 8;
    localparam int NUM_PRG_WIN = 4;
    localparam int NUM_CHR_WIN = 8;
    localparam int NUM_IDX_REG = 8;

    typedef enum logic [1:0] {
        PERS_NIBBLE = 2'd0,
        PERS_INDEX  = 2'd1,
        PERS_SER_A  = 2'd2,
        PERS_SER_B  = 2'd3
    } pers_e;

    // Character register picked by a nibble-personality write address.
    function automatic logic [2:0] nib_index(input logic [CPU_AW-1:0] a);
        logic [CPU_AW-1:0] t;
        t = (a >> 10) | (a & 16'h0002);
        return 3'((t >> 1) + 16'd2);
    endfunction

endpackage

// File: rtl/mbt_nib_regs.sv
// Module: register file of the nibble personality.
// Holds two program selects, eight nibble-written character registers and
// the mirroring bit. Assumes wr_en is already qualified by the personality
// and by address bit 15.
module mbt_nib_regs
    import mbt_pkg::*;
#(
    parameter int DW = CPU_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     prg_sel [2],
    output logic [DW-1:0]     chr_sel [NUM_CHR_WIN],
    output logic              mir_h
);

    localparam int NIB = DW / 2;

    logic [2:0] wr_idx;
    logic       in_chr_range;

    // Decode the nibble-register target of the current address.
    always_comb begin
        wr_idx       = nib_index(wr_addr);
        in_chr_range = (wr_addr >= 16'hB000) && (wr_addr <= 16'hE003);
    end

    // Load program, character and mirroring registers on qualified writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prg_sel[0] <= DW'(0);
            prg_sel[1] <= DW'(1);
            mir_h      <= 1'b0;
            for (int i = 0; i < NUM_CHR_WIN; i++) begin
                chr_sel[i] <= (i < 4) ? {DW{1'b1}} : DW'(i);
            end
        end else if (wr_en) begin
            if (in_chr_range) begin
                if (wr_addr[0])
                    chr_sel[wr_idx][DW-1:NIB] <= wr_data[NIB-1:0];
                else
                    chr_sel[wr_idx][NIB-1:0]  <= wr_data[NIB-1:0];
            end else begin
                case (wr_addr[15:12])
                    4'h8:    prg_sel[0] <= wr_data;
                    4'hA:    prg_sel[1] <= wr_data;
                    4'h9:    mir_h      <= wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    // R4: a window-0 write lands in the first program select
    a_r4_prg0_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'h8) |=> prg_sel[0] == $past(wr_data));

    // R5: a high-nibble write updates only the upper half
    a_r5_high_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_chr_range && wr_addr[0])
        |=> chr_sel[$past(wr_idx)][DW-1:NIB] == $past(wr_data[NIB-1:0])
            && chr_sel[$past(wr_idx)][NIB-1:0] == $past(chr_sel[wr_idx][NIB-1:0]));

    // R6: mirroring follows bit 0 of a 0x9xxx write
    a_r6_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_chr_range && wr_addr[15:12] == 4'h9) |=> mir_h == $past(wr_data[0]));

endmodule

// File: rtl/mbt_idx_regs.sv
// Module: register file of the indexed personality.
// A control byte selects which of eight data registers the next data write
// fills. Assumes wr_en is already qualified by the personality and by
// address bit 15.
module mbt_idx_regs
    import mbt_pkg::*;
#(
    parameter int DW = CPU_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     ctrl,
    output logic [DW-1:0]     data_reg [NUM_IDX_REG],
    output logic              mir_h
);

    localparam logic [CPU_AW-1:0] DEC_MASK = 16'hE001;

    logic [CPU_AW-1:0] dec_addr;

    // Reduce the address to its decoded form.
    always_comb dec_addr = wr_addr & DEC_MASK;

    // Load control, data and mirroring registers on qualified writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl        <= '0;
            mir_h       <= 1'b0;
            data_reg[0] <= DW'(8'h00);
            data_reg[1] <= DW'(8'h02);
            data_reg[2] <= DW'(8'h04);
            data_reg[3] <= DW'(8'h05);
            data_reg[4] <= DW'(8'h06);
            data_reg[5] <= DW'(8'h07);
            data_reg[6] <= DW'(8'hFC);
            data_reg[7] <= DW'(8'hFD);
        end else if (wr_en) begin
            case (dec_addr)
                16'h8000: ctrl                 <= wr_data;
                16'h8001: data_reg[ctrl[2:0]]  <= wr_data;
                16'hA000: mir_h                <= wr_data[0];
                default:  ;
            endcase
        end
    end

    // R7: a data write lands in the register named by the control byte
    a_r7_data_target: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec_addr == 16'h8001) |=> data_reg[$past(ctrl[2:0])] == $past(wr_data));

    // R7: a control write replaces the control byte
    a_r7_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec_addr == 16'h8000) |=> ctrl == $past(wr_data));

endmodule

// File: rtl/mbt_window_map.sv
// Module: window resolution for both personalities.
// Purely combinational: turns the register files and mode into program and
// character bank numbers and a mirroring bit. Assumes PRG_W >= 2.
module mbt_window_map
    import mbt_pkg::*;
#(
    parameter int PRG_W = 5,
    parameter int DW    = CPU_DW,
    parameter int CW    = DW + 1
) (
    input  logic [2:0]       mode,
    input  logic [DW-1:0]    nib_prg [2],
    input  logic [DW-1:0]    nib_chr [NUM_CHR_WIN],
    input  logic             nib_mir,
    input  logic [DW-1:0]    idx_ctrl,
    input  logic [DW-1:0]    idx_reg [NUM_IDX_REG],
    input  logic             idx_mir,
    output logic [PRG_W-1:0] prg [NUM_PRG_WIN],
    output logic [CW-1:0]    chr [NUM_CHR_WIN],
    output logic             mir_h
);

    localparam logic [PRG_W-1:0] LAST_BANK  = '1;
    localparam logic [PRG_W-1:0] SLAST_BANK = {{(PRG_W-1){1'b1}}, 1'b0};

    logic idx_mode;

    // Flag the indexed personality; every other mode resolves as nibble.
    always_comb idx_mode = (pers_e'(mode[1:0]) == PERS_INDEX);

    // Resolve program windows and mirroring.
    always_comb begin
        if (idx_mode) begin
            prg[0] = idx_ctrl[6] ? SLAST_BANK : idx_reg[6][PRG_W-1:0];
            prg[1] = idx_reg[7][PRG_W-1:0];
            prg[2] = idx_ctrl[6] ? idx_reg[6][PRG_W-1:0] : SLAST_BANK;
            prg[3] = LAST_BANK;
            mir_h  = idx_mir;
        end else begin
            prg[0] = nib_prg[0][PRG_W-1:0];
            prg[1] = nib_prg[1][PRG_W-1:0];
            prg[2] = SLAST_BANK;
            prg[3] = LAST_BANK;
            mir_h  = nib_mir;
        end
    end

    for (genvar k = 0; k < NUM_CHR_WIN; k++) begin : g_chr
        logic [2:0]    slot;
        logic [DW-1:0] idx_val;

        // Map this window back to its logical slot and pick its bank.
        always_comb begin
            slot = 3'(k) ^ {idx_ctrl[7], 2'b00};
            if (!slot[2])
                idx_val = {idx_reg[{2'b00, slot[1]}][DW-1:1], slot[0]};
            else
                idx_val = idx_reg[3'(slot[1:0]) + 3'd2];
            chr[k] = {mode[2], idx_mode ? idx_val : nib_chr[k]};
        end
    end

endmodule

// File: rtl/multi_bank_xlate.sv
// Module: top of the multi-personality bank address translator.
// Holds the mode register, routes high writes to the active personality
// and flattens the resolved windows onto ports. Assumes PRG_BANKS is a
// power of two between 4 and 256.
module multi_bank_xlate
    import mbt_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    parameter int PRG_W     = $clog2(PRG_BANKS),
    parameter int CW        = CPU_DW + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CPU_AW-1:0]            wr_addr,
    input  logic [CPU_DW-1:0]            wr_data,
    output logic [NUM_PRG_WIN*PRG_W-1:0] prg_banks,
    output logic [NUM_CHR_WIN*CW-1:0]    chr_banks,
    output logic                         mirror_h
);

    logic [2:0]        mode_q;
    logic              mode_we, nib_we, idx_we;
    logic [CPU_DW-1:0] nib_prg [2];
    logic [CPU_DW-1:0] nib_chr [NUM_CHR_WIN];
    logic              nib_mir;
    logic [CPU_DW-1:0] idx_ctrl;
    logic [CPU_DW-1:0] idx_reg [NUM_IDX_REG];
    logic              idx_mir;
    logic [PRG_W-1:0]  prg [NUM_PRG_WIN];
    logic [CW-1:0]     chr [NUM_CHR_WIN];

    // Split incoming writes between the mode register and the personalities.
    always_comb begin
        mode_we = wr_en && !wr_addr[15] && ((wr_addr & 16'h4100) == 16'h4100);
        nib_we  = wr_en && wr_addr[15] && (pers_e'(mode_q[1:0]) == PERS_NIBBLE);
        idx_we  = wr_en && wr_addr[15] && (pers_e'(mode_q[1:0]) == PERS_INDEX);
    end

    // Mode register: personality select plus outer character bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 3'd0;
        else if (mode_we) mode_q <= wr_data[2:0];
    end

    mbt_nib_regs #(.DW(CPU_DW)) u_nib (
        .clk(clk), .rst_n(rst_n), .wr_en(nib_we), .wr_addr(wr_addr),
        .wr_data(wr_data), .prg_sel(nib_prg), .chr_sel(nib_chr), .mir_h(nib_mir)
    );

    mbt_idx_regs #(.DW(CPU_DW)) u_idx (
        .clk(clk), .rst_n(rst_n), .wr_en(idx_we), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(idx_ctrl), .data_reg(idx_reg), .mir_h(idx_mir)
    );

    mbt_window_map #(.PRG_W(PRG_W), .DW(CPU_DW), .CW(CW)) u_map (
        .mode(mode_q), .nib_prg(nib_prg), .nib_chr(nib_chr), .nib_mir(nib_mir),
        .idx_ctrl(idx_ctrl), .idx_reg(idx_reg), .idx_mir(idx_mir),
        .prg(prg), .chr(chr), .mir_h(mirror_h)
    );

    for (genvar w = 0; w < NUM_PRG_WIN; w++) begin : g_prg_out
        assign prg_banks[w*PRG_W +: PRG_W] = prg[w];
    end
    for (genvar k = 0; k < NUM_CHR_WIN; k++) begin : g_chr_out
        assign chr_banks[k*CW +: CW] = chr[k];
    end

    // R2: a decoded low write loads the mode bits
    a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> mode_q == $past(wr_data[2:0]));

    // R3: every character window carries the outer bit from the mode
    a_r3_outer_bit: assert property (@(posedge clk) disable iff (!rst_n)
        chr_banks[CW-1] == mode_q[2] && chr_banks[NUM_CHR_WIN*CW-1] == mode_q[2]);

    // R8: window 3 is the last bank whatever the personality
    a_r8_last_window: assert property (@(posedge clk) disable iff (!rst_n)
        prg_banks[NUM_PRG_WIN*PRG_W-1 -: PRG_W] == {PRG_W{1'b1}});

    // R11: high writes in the unhandled modes leave every output alone
    a_r11_serial_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15] && mode_q[1])
        |=> $stable(prg_banks) && $stable(chr_banks) && $stable(mirror_h));

endmodule

// File: tb/tb_multi_bank_xlate.sv
`timescale 1ns/1ps
module tb_multi_bank_xlate;

    localparam int PRG_BANKS = 32;
    localparam int PW        = 5;
    localparam int CW        = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [15:0]       wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [4*PW-1:0]   prg_banks;
    logic [8*CW-1:0]   chr_banks;
    logic              mirror_h;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference state built from the requirements.
    logic [2:0] m_mode;
    logic [7:0] m_nprg [2];
    logic [7:0] m_nchr [8];
    logic       m_nmir;
    logic [7:0] m_ctrl;
    logic [7:0] m_ireg [8];
    logic       m_imir;

    multi_bank_xlate #(.PRG_BANKS(PRG_BANKS)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prg_banks(prg_banks), .chr_banks(chr_banks),
        .mirror_h(mirror_h)
    );

    always #2 clk = ~clk;

    task automatic model_reset();
        m_mode = 3'd0;
        m_nprg[0] = 8'd0; m_nprg[1] = 8'd1;
        for (int i = 0; i < 8; i++) m_nchr[i] = (i < 4) ? 8'hFF : 8'(i);
        m_nmir = 1'b0;
        m_ctrl = 8'd0;
        m_ireg[0] = 8'h00; m_ireg[1] = 8'h02; m_ireg[2] = 8'h04; m_ireg[3] = 8'h05;
        m_ireg[4] = 8'h06; m_ireg[5] = 8'h07; m_ireg[6] = 8'hFC; m_ireg[7] = 8'hFD;
        m_imir = 1'b0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        logic [15:0] t;
        logic [2:0]  idx;
        if (a < 16'h8000) begin
            if ((a & 16'h4100) == 16'h4100) m_mode = d[2:0];
        end else if (m_mode[1:0] == 2'd0) begin
            if (a >= 16'hB000 && a <= 16'hE003) begin
                t   = (a >> 10) | (a & 16'h0002);
                idx = 3'((t >> 1) + 16'd2);
                if (a[0]) m_nchr[idx][7:4] = d[3:0];
                else      m_nchr[idx][3:0] = d[3:0];
            end else if ((a & 16'hF000) == 16'h8000) m_nprg[0] = d;
            else if ((a & 16'hF000) == 16'hA000) m_nprg[1] = d;
            else if ((a & 16'hF000) == 16'h9000) m_nmir = d[0];
        end else if (m_mode[1:0] == 2'd1) begin
            case (a & 16'hE001)
                16'h8000: m_ctrl = d;
                16'h8001: m_ireg[m_ctrl[2:0]] = d;
                16'hA000: m_imir = d[0];
                default: ;
            endcase
        end
    endtask

    function automatic logic [PW-1:0] exp_prg(input int w);
        logic [7:0] v;
        if (m_mode[1:0] == 2'd1) begin
            case (w)
                0: v = m_ctrl[6] ? 8'(PRG_BANKS-2) : m_ireg[6];
                1: v = m_ireg[7];
                2: v = m_ctrl[6] ? m_ireg[6] : 8'(PRG_BANKS-2);
                default: v = 8'(PRG_BANKS-1);
            endcase
        end else begin
            case (w)
                0: v = m_nprg[0];
                1: v = m_nprg[1];
                2: v = 8'(PRG_BANKS-2);
                default: v = 8'(PRG_BANKS-1);
            endcase
        end
        return PW'(v % PRG_BANKS);
    endfunction

    function automatic logic [CW-1:0] exp_chr(input int k);
        int s;
        logic [7:0] v;
        if (m_mode[1:0] == 2'd1) begin
            s = m_ctrl[7] ? (k ^ 4) : k;
            if (s < 4) v = s[0] ? (m_ireg[s/2] | 8'h01) : (m_ireg[s/2] & 8'hFE);
            else       v = m_ireg[s-2];
        end else begin
            v = m_nchr[k];
        end
        return {m_mode[2], v};
    endfunction

    task automatic check_all(input string tag);
        for (int w = 0; w < 4; w++) begin
            checks++;
            if (prg_banks[w*PW +: PW] !== exp_prg(w)) begin
                errors++;
                $display("FAIL %s prg window %0d: got %0d expected %0d", tag, w,
                         prg_banks[w*PW +: PW], exp_prg(w));
            end
        end
        for (int k = 0; k < 8; k++) begin
            checks++;
            if (chr_banks[k*CW +: CW] !== exp_chr(k)) begin
                errors++;
                $display("FAIL %s chr window %0d: got 0x%0h expected 0x%0h", tag, k,
                         chr_banks[k*CW +: CW], exp_chr(k));
            end
        end
        checks++;
        if (mirror_h !== (m_mode[1:0] == 2'd1 ? m_imir : m_nmir)) begin
            errors++;
            $display("FAIL %s mirroring: got %0b expected %0b", tag, mirror_h,
                     (m_mode[1:0] == 2'd1 ? m_imir : m_nmir));
        end
    endtask

    // Drive one write between falling edges, then sample after the capture edge.
    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic wr_check(input logic [15:0] a, input logic [7:0] d, input string tag);
        cpu_write(a, d);
        check_all(tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        logic [7:0]  d;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2: only one mask bit matches -> ignored
        wr_check(16'h4001, 8'h01, "R2");
        wr_check(16'h0100, 8'h01, "R2");
        // R5: nibble ends of the range and one past it
        wr_check(16'hB000, 8'h03, "R5");
        wr_check(16'hB001, 8'h0C, "R5");
        wr_check(16'hE003, 8'h09, "R5");
        wr_check(16'hE004, 8'h05, "R5");
        wr_check(16'hC002, 8'hF6, "R5");
        // R4 / R12: wide bank values wrap modulo PRG_BANKS
        wr_check(16'h8000, 8'hE5, "R12");
        wr_check(16'hAFFF, 8'h3B, "R4");
        // R6
        wr_check(16'h9000, 8'h01, "R6");
        // R3: outer character bit
        wr_check(16'h4100, 8'h04, "R3");
        // R2 / R10: switch to indexed personality, reset contents visible
        wr_check(16'h5100, 8'h01, "R10");
        // R7 / R8 / R9: control swaps and data loads
        wr_check(16'h8001, 8'h2A, "R7");
        wr_check(16'h8000, 8'h46, "R8");
        wr_check(16'h8001, 8'h11, "R8");
        wr_check(16'h8000, 8'h87, "R9");
        wr_check(16'h8001, 8'h13, "R8");
        wr_check(16'h8000, 8'h80, "R9");
        wr_check(16'h8001, 8'h31, "R9");
        wr_check(16'hA000, 8'h01, "R7");
        wr_check(16'hA001, 8'h00, "R7");
        wr_check(16'hC000, 8'h55, "R7");
        // R11: serial modes drop high writes, show nibble resolution
        wr_check(16'h4101, 8'h02, "R11");
        wr_check(16'h8000, 8'h00, "R11");
        wr_check(16'hB000, 8'h0F, "R11");
        wr_check(16'h7F13, 8'h03, "R11");
        wr_check(16'hE000, 8'h80, "R11");

        for (int n = 0; n < 3000; n++) begin
            string tag;
            int kind;
            kind = $urandom % 8;
            d = 8'($urandom);
            if (kind == 0) begin
                a = 16'h4100 | 16'($urandom & 32'h3EFF);
                if ($urandom % 4 != 0) d = {5'($urandom), d[2], 1'b0, d[0]};
            end else if (kind == 1) begin
                a = 16'($urandom & 32'h7FFF);
            end else if (kind == 2) begin
                a = 16'h8000 | 16'($urandom);
            end else begin
                a = {1'b1, 3'($urandom), 10'd0, 2'($urandom)};
            end
            if (a < 16'h8000)             tag = "R2";
            else if (m_mode[1:0] == 2'd0) tag = "R5";
            else if (m_mode[1:0] == 2'd1) tag = "R9";
            else                          tag = "R11";
            wr_check(a, d, tag);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule